// File: doc/BRIEF.md
# Fixed-Format Instruction Decode and Execute Unit

This block is the combined decode and execute stage of a small 32-bit RISC pipeline. Each accepted cycle it takes one 32-bit instruction word together with the values already read for the two source registers. It sorts the word into one of three fixed layouts: immediate, register or jump. It pulls out the register indices and the immediate fields and computes the result of the operation. One cycle later it presents registered outputs: a destination index, the result, a write enable and an illegal-instruction flag.

The supported operations are register add and subtract, add-immediate with a sign-extended 16-bit constant, OR with a constant placed in the upper half-word, the three shifts and the two rotates. Shifts and rotates come in immediate-amount and register-amount forms. The jump format (the call) is recognised but writes nothing, because program-counter handling lives elsewhere. The register file and memory are outside the block.

Top module: `dexu_core`

## Requirements
- R1: While reset is high, and on the first output cycle after it, out_valid, out_we, out_illegal, out_fmt, out_dest and out_result are all zero.
- R2: A word presented with in_valid high in one cycle shows its results with out_valid high after the next rising edge. Cycles without in_valid give out_valid, out_we and out_illegal low.
- R3: The format comes from op = instr[5:0]. An op of 0x3A gives out_fmt 1 (register form). An op of 0x00 gives out_fmt 2 (call, jump form), which is legal but has out_we low. op 0x04 and 0x34 give out_fmt 0 (immediate form). Any other op gives out_fmt 3.
- R4: Field positions: rA = instr[31:27], rB = instr[26:22]. In the immediate form Imm16 = instr[21:6]. In the register form rC = instr[21:17], opx = instr[16:11] and Imm5 = instr[10:6].
- R5: In the register form, opx 0x31 writes opa + opb and opx 0x39 writes opa - opb, both modulo 2^32, to destination rC.
- R6: op 0x04 writes opa plus Imm16 sign-extended to 32 bits, to destination rB.
- R7: op 0x34 writes opa OR (Imm16 << 16) to destination rB, leaving the low half of opa unchanged.
- R8: Immediate-amount shifts (register form, amount Imm5, source opa, destination rC): opx 0x12 shifts left and fills with zeros. opx 0x1A shifts right and fills with zeros. opx 0x3A shifts right and fills with copies of opa[31].
- R9: Register-amount shifts use opb[4:0] as the amount and ignore opb[31:5]: opx 0x13 is left logical, 0x1B is right logical and 0x3B is right arithmetic. The destination is rC.
- R10: Rotates recirculate the bits shifted out: opx 0x02 rotates left by Imm5, opx 0x03 rotates left by opb[4:0] and opx 0x0B rotates right by opb[4:0]. The destination is rC.
- R11: An unsupported op, or an unsupported opx under op 0x3A, sets out_illegal and clears out_we, with out_dest and out_result forced to zero.
- R12: A legal writing instruction whose destination index is 0 gives out_we low, while out_dest and out_result still carry the computed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 32 | Value of the register named by rA |
| in_opb | input | 32 | Value of the register named by rB |
| out_valid | output | 1 | Registered results are valid |
| out_fmt | output | 2 | Format: 0 immediate, 1 register, 2 jump, 3 unknown |
| out_dest | output | 5 | Destination register index |
| out_result | output | 32 | Computed result |
| out_we | output | 1 | Register write enable |
| out_illegal | output | 1 | Instruction not in the supported subset |

## Verification
Every result of this block is due exactly one rising edge after its word is presented: destination, value, write enable, illegal flag and format all leave the same output register. The bench drives each word just after a falling edge. It queues the expected outcome from a requirement-level model, and it compares the outputs two time units after the following rising edge, once per cycle in which out_valid is high. Words go in back to back and with idle gaps, so the check pairs each result with its own word and not a neighbour's, and idle cycles are checked for a quiet write enable.

// File: rtl/dexu_pkg.sv
package dexu_pkg;

  localparam int INSTR_W = 32;
  localparam int DATA_W  = 32;
  localparam int REG_AW  = 5;
  localparam int OP_W    = 6;
  localparam int IMM16_W = 16;
  localparam int IMM5_W  = 5;

  // Field positions of the fixed instruction layouts
  localparam int RA_LSB    = 27;
  localparam int RB_LSB    = 22;
  localparam int RC_LSB    = 17;
  localparam int IMM16_LSB = 6;
  localparam int OPX_LSB   = 11;
  localparam int IMM5_LSB  = 6;

  // Major opcodes
  localparam logic [OP_W-1:0] OPC_CALL  = 6'h00;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h04;
  localparam logic [OP_W-1:0] OPC_ORHI  = 6'h34;
  localparam logic [OP_W-1:0] OPC_REG   = 6'h3A;

  // Sub-opcodes of the register form
  localparam logic [OP_W-1:0] SUB_ADD  = 6'h31;
  localparam logic [OP_W-1:0] SUB_SUB  = 6'h39;
  localparam logic [OP_W-1:0] SUB_SLLI = 6'h12;
  localparam logic [OP_W-1:0] SUB_SLL  = 6'h13;
  localparam logic [OP_W-1:0] SUB_SRLI = 6'h1A;
  localparam logic [OP_W-1:0] SUB_SRL  = 6'h1B;
  localparam logic [OP_W-1:0] SUB_SRAI = 6'h3A;
  localparam logic [OP_W-1:0] SUB_SRA  = 6'h3B;
  localparam logic [OP_W-1:0] SUB_ROLI = 6'h02;
  localparam logic [OP_W-1:0] SUB_ROL  = 6'h03;
  localparam logic [OP_W-1:0] SUB_ROR  = 6'h0B;

  typedef enum logic [1:0] {
    FMT_IMM  = 2'd0,
    FMT_REG  = 2'd1,
    FMT_JMP  = 2'd2,
    FMT_UNKN = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_ADD   = 3'd1,
    K_SUB   = 3'd2,
    K_ADDI  = 3'd3,
    K_ORHI  = 3'd4,
    K_SHIFT = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    SH_LLEFT  = 3'd0,
    SH_LRIGHT = 3'd1,
    SH_ARIGHT = 3'd2,
    SH_ROLEFT = 3'd3,
    SH_RORGHT = 3'd4
  } shmode_e;

  typedef struct packed {
    fmt_e                 fmt;
    kind_e                kind;
    shmode_e              shmode;
    logic                 amt_from_reg;
    logic                 legal;
    logic                 writes;
    logic [REG_AW-1:0]    dest;
    logic [IMM16_W-1:0]   imm16;
    logic [IMM5_W-1:0]    imm5;
  } decoded_t;

endpackage

// File: rtl/dexu_decode.sv
module dexu_decode
  import dexu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decoded_t           dec
);

  logic [OP_W-1:0]   op;
  logic [OP_W-1:0]   opx;
  logic [REG_AW-1:0] f_rb;
  logic [REG_AW-1:0] f_rc;

  assign op   = instr[OP_W-1:0];
  assign opx  = instr[OPX_LSB +: OP_W];
  assign f_rb = instr[RB_LSB +: REG_AW];
  assign f_rc = instr[RC_LSB +: REG_AW];

  always_comb begin
    dec              = '0;
    dec.imm16        = instr[IMM16_LSB +: IMM16_W];
    dec.imm5         = instr[IMM5_LSB +: IMM5_W];
    dec.kind         = K_NONE;
    dec.shmode       = SH_LLEFT;
    dec.amt_from_reg = 1'b0;
    unique case (op)
      OPC_CALL: begin
        dec.fmt   = FMT_JMP;
        dec.legal = 1'b1;
      end
      OPC_ADDI: begin
        dec.fmt    = FMT_IMM;
        dec.kind   = K_ADDI;
        dec.legal  = 1'b1;
        dec.writes = 1'b1;
        dec.dest   = f_rb;
      end
      OPC_ORHI: begin
        dec.fmt    = FMT_IMM;
        dec.kind   = K_ORHI;
        dec.legal  = 1'b1;
        dec.writes = 1'b1;
        dec.dest   = f_rb;
      end
      OPC_REG: begin
        dec.fmt    = FMT_REG;
        dec.legal  = 1'b1;
        dec.writes = 1'b1;
        dec.dest   = f_rc;
        dec.kind   = K_SHIFT;
        unique case (opx)
          SUB_ADD:  dec.kind = K_ADD;
          SUB_SUB:  dec.kind = K_SUB;
          SUB_SLLI: dec.shmode = SH_LLEFT;
          SUB_SLL:  begin dec.shmode = SH_LLEFT;  dec.amt_from_reg = 1'b1; end
          SUB_SRLI: dec.shmode = SH_LRIGHT;
          SUB_SRL:  begin dec.shmode = SH_LRIGHT; dec.amt_from_reg = 1'b1; end
          SUB_SRAI: dec.shmode = SH_ARIGHT;
          SUB_SRA:  begin dec.shmode = SH_ARIGHT; dec.amt_from_reg = 1'b1; end
          SUB_ROLI: dec.shmode = SH_ROLEFT;
          SUB_ROL:  begin dec.shmode = SH_ROLEFT; dec.amt_from_reg = 1'b1; end
          SUB_ROR:  begin dec.shmode = SH_RORGHT; dec.amt_from_reg = 1'b1; end
          default: begin
            dec.kind   = K_NONE;
            dec.legal  = 1'b0;
            dec.writes = 1'b0;
            dec.dest   = '0;
          end
        endcase
      end
      default: begin
        dec.fmt = FMT_UNKN;
      end
    endcase
  end

  // A decoded writer always has a real operation behind it
  always_comb begin
    if (dec.writes)
      assert_writer_has_op_R11: assert (dec.legal && dec.kind != K_NONE);
  end

endmodule

// File: rtl/dexu_shifter.sv
module dexu_shifter
  import dexu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  shmode_e          mode,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [AMT_W+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      unique case (mode)
        SH_LLEFT:  moved = {stg[k][WIDTH-1-D:0], {D{1'b0}}};
        SH_LRIGHT: moved = {{D{1'b0}}, stg[k][WIDTH-1:D]};
        SH_ARIGHT: moved = {{D{stg[k][WIDTH-1]}}, stg[k][WIDTH-1:D]};
        SH_ROLEFT: moved = {stg[k][WIDTH-1-D:0], stg[k][WIDTH-1:WIDTH-D]};
        default:   moved = {stg[k][D-1:0], stg[k][WIDTH-1:D]};
      endcase
    end
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[AMT_W];

  always_comb begin
    if (amt == '0)
      assert_zero_amount_passes_R8: assert (dout == din);
    if (mode == SH_ROLEFT || mode == SH_RORGHT)
      assert_rotate_keeps_bits_R10: assert ($countones(dout) == $countones(din));
  end

endmodule

// File: rtl/dexu_alu.sv
module dexu_alu
  import dexu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  decoded_t         dec,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] imm_sext;
  logic [WIDTH-1:0] imm_high;
  logic [AMT_W-1:0] sh_amt;
  logic [WIDTH-1:0] sh_out;

  assign imm_sext = {{(WIDTH-IMM16_W){dec.imm16[IMM16_W-1]}}, dec.imm16};
  assign imm_high = {dec.imm16, {(WIDTH-IMM16_W){1'b0}}};
  assign sh_amt   = dec.amt_from_reg ? opb[AMT_W-1:0] : dec.imm5[AMT_W-1:0];

  dexu_shifter #(.WIDTH(WIDTH)) u_shift (
    .din  (opa),
    .amt  (sh_amt),
    .mode (dec.shmode),
    .dout (sh_out)
  );

  always_comb begin
    unique case (dec.kind)
      K_ADD:   result = opa + opb;
      K_SUB:   result = opa - opb;
      K_ADDI:  result = opa + imm_sext;
      K_ORHI:  result = opa | imm_high;
      K_SHIFT: result = sh_out;
      default: result = '0;
    endcase
  end

  always_comb begin
    if (dec.kind == K_ORHI)
      assert_orhi_low_half_kept_R7: assert (result[IMM16_W-1:0] == opa[IMM16_W-1:0]);
  end

endmodule

// File: rtl/dexu_core.sv
module dexu_core
  import dexu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic [DATA_W-1:0]    in_opa,
  input  logic [DATA_W-1:0]    in_opb,
  output logic                 out_valid,
  output logic [1:0]           out_fmt,
  output logic [REG_AW-1:0]    out_dest,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_we,
  output logic                 out_illegal
);

  decoded_t          dec;
  logic [DATA_W-1:0] alu_res;

  dexu_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  dexu_alu #(.WIDTH(DATA_W)) u_alu (
    .dec    (dec),
    .opa    (in_opa),
    .opb    (in_opb),
    .result (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_fmt     <= 2'd0;
      out_dest    <= '0;
      out_result  <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_we      <= in_valid && dec.legal && dec.writes && (dec.dest != '0);
      out_illegal <= in_valid && !dec.legal;
      if (in_valid) begin
        out_fmt    <= dec.fmt;
        out_dest   <= dec.legal ? dec.dest : '0;
        out_result <= dec.legal ? alu_res : '0;
      end
    end
  end

  assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_is_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_we && !out_illegal));

  assert_illegal_blocks_write_R11: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_we && out_result == '0 && out_dest == '0));

  assert_r0_never_written_R12: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_dest != '0));

  assert_call_writes_nothing_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt == 2'd2) |-> (!out_we && !out_illegal));

  assert_unknown_fmt_illegal_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt == 2'd3) |-> out_illegal);

endmodule

// File: tb/dexu_core_tb_top.sv
module dexu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    logic [1:0]  fmt;
    logic [4:0]  dest;
    logic [31:0] result;
    logic        we;
    logic        illegal;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        out_valid;
  logic [1:0]  out_fmt;
  logic [4:0]  out_dest;
  logic [31:0] out_result;
  logic        out_we;
  logic        out_illegal;

  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dexu_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid), .out_fmt(out_fmt),
    .out_dest(out_dest), .out_result(out_result), .out_we(out_we),
    .out_illegal(out_illegal)
  );

  function automatic logic [31:0] enc_i(input logic [4:0] ra, input logic [4:0] rb,
                                        input logic [15:0] imm, input logic [5:0] op);
    return {ra, rb, imm, op};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] ra, input logic [4:0] rb,
                                        input logic [4:0] rc, input logic [5:0] opx,
                                        input logic [4:0] imm5);
    return {ra, rb, rc, opx, imm5, 6'h3A};
  endfunction

  // Requirement-level model of one instruction
  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input string req);
    exp_t        e;
    logic [5:0]  op;
    logic [5:0]  opx;
    logic [4:0]  n;
    logic [63:0] dbl;
    bit          ok;
    op  = w[5:0];
    opx = w[16:11];
    e.req = req;
    e.result = '0; e.dest = '0; e.we = 1'b0; e.illegal = 1'b0; e.fmt = 2'd3;
    ok = 1'b1;
    dbl = {a, a};
    if (op == 6'h00) begin
      e.fmt = 2'd2;
    end else if (op == 6'h04) begin
      e.fmt = 2'd0; e.dest = w[26:22];
      e.result = a + {{16{w[21]}}, w[21:6]};
    end else if (op == 6'h34) begin
      e.fmt = 2'd0; e.dest = w[26:22];
      e.result = a | {w[21:6], 16'h0000};
    end else if (op == 6'h3A) begin
      e.fmt = 2'd1; e.dest = w[21:17];
      n = (opx == 6'h12 || opx == 6'h1A || opx == 6'h3A || opx == 6'h02) ? w[10:6] : b[4:0];
      case (opx)
        6'h31: e.result = a + b;
        6'h39: e.result = a - b;
        6'h12, 6'h13: e.result = a << n;
        6'h1A, 6'h1B: e.result = a >> n;
        6'h3A, 6'h3B: e.result = $unsigned($signed(a) >>> n);
        6'h02, 6'h03: begin dbl = dbl << n; e.result = dbl[63:32]; end
        6'h0B: begin dbl = dbl >> n; e.result = dbl[31:0]; end
        default: ok = 1'b0;
      endcase
    end else begin
      ok = 1'b0;
    end
    if (!ok) begin
      e.illegal = 1'b1; e.dest = '0; e.result = '0;
    end else if (op != 6'h00) begin
      e.we = (e.dest != 5'd0);
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_opa = a; in_opb = b;
    sb_q.push_back(model(w, a, b, req));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_instr = $urandom; in_opa = $urandom; in_opb = $urandom;
    end
  endtask

  // Monitor: compare two time units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && out_valid) begin
        n_tests++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (out_fmt !== e.fmt || out_dest !== e.dest || out_result !== e.result ||
              out_we !== e.we || out_illegal !== e.illegal) begin
            n_fail++;
            $display("FAIL %s: actual fmt=%0d dest=%0d res=%h we=%b ill=%b expected fmt=%0d dest=%0d res=%h we=%b ill=%b",
                     e.req, out_fmt, out_dest, out_result, out_we, out_illegal,
                     e.fmt, e.dest, e.result, e.we, e.illegal);
          end
        end
      end
    end
  end

  task automatic check_quiet(input string req);
    @(posedge clk);
    #2;
    n_tests++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual valid=%b we=%b ill=%b expected 0 0 0",
               req, out_valid, out_we, out_illegal);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    n_tests++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_illegal !== 1'b0 ||
        out_fmt !== 2'd0 || out_dest !== 5'd0 || out_result !== 32'd0) begin
      n_fail++;
      $display("FAIL R1: actual valid=%b we=%b ill=%b fmt=%0d dest=%0d res=%h expected all zero",
               out_valid, out_we, out_illegal, out_fmt, out_dest, out_result);
    end
    rst = 1'b0;
    check_quiet("R1");

    // R5 add / sub, R4 field positions
    drive(enc_r(5'd3, 5'd4, 5'd7, 6'h31, 5'd0), 32'h0000_1234, 32'h0000_0FFF, "R5");
    drive(enc_r(5'd3, 5'd4, 5'd9, 6'h39, 5'd0), 32'h0000_0001, 32'h0000_0002, "R5");
    drive(enc_r(5'd1, 5'd2, 5'd31, 6'h31, 5'd0), 32'hFFFF_FFFF, 32'h0000_0001, "R4");
    // R6 addi
    drive(enc_i(5'd9, 5'd8, 16'hFFF0, 6'h04), 32'h0000_0100, 32'hDEAD_BEEF, "R6");
    drive(enc_i(5'd9, 5'd17, 16'h7FFF, 6'h04), 32'h0000_0001, 32'h0, "R6");
    drive(enc_i(5'd0, 5'd8, 16'hF000, 6'h04), 32'h0021_0000, 32'h0, "R6");
    // R7 orhi
    drive(enc_i(5'd0, 5'd8, 16'h0025, 6'h34), 32'h0000_0000, 32'h0, "R7");
    drive(enc_i(5'd5, 5'd6, 16'hA500, 6'h34), 32'h0F0F_1234, 32'h0, "R7");
    idle(2);
    check_quiet("R2");
    // R8 immediate shifts
    drive(enc_r(5'd9, 5'd0, 5'd8, 6'h12, 5'd4), 32'h8000_00F1, 32'h0, "R8");
    drive(enc_r(5'd9, 5'd0, 5'd8, 6'h1A, 5'd3), 32'h8000_00F8, 32'h0, "R8");
    drive(enc_r(5'd9, 5'd0, 5'd8, 6'h3A, 5'd2), 32'hFFFF_FFF8, 32'h0, "R8");
    drive(enc_r(5'd9, 5'd0, 5'd8, 6'h3A, 5'd3), 32'h7000_0040, 32'h0, "R8");
    drive(enc_r(5'd9, 5'd0, 5'd8, 6'h3A, 5'd31), 32'h8000_0000, 32'h0, "R8");
    // R9 register shifts, upper amount bits ignored
    drive(enc_r(5'd9, 5'd10, 5'd11, 6'h13, 5'd0), 32'h0000_0003, 32'hFFFF_FFE5, "R9");
    drive(enc_r(5'd9, 5'd10, 5'd11, 6'h1B, 5'd0), 32'hF000_0000, 32'h0000_0104, "R9");
    drive(enc_r(5'd9, 5'd10, 5'd11, 6'h3B, 5'd0), 32'h8000_0010, 32'h0000_001F, "R9");
    // R10 rotates
    drive(enc_r(5'd9, 5'd0, 5'd12, 6'h02, 5'd1), 32'hB100_0001, 32'h0, "R10");
    drive(enc_r(5'd9, 5'd0, 5'd12, 6'h02, 5'd0), 32'h1234_5678, 32'h0, "R10");
    drive(enc_r(5'd9, 5'd10, 5'd12, 6'h03, 5'd0), 32'h8000_0003, 32'h0000_0022, "R10");
    drive(enc_r(5'd9, 5'd10, 5'd12, 6'h0B, 5'd0), 32'h0000_00B1, 32'h0000_0002, "R10");
    drive(enc_r(5'd9, 5'd10, 5'd12, 6'h0B, 5'd0), 32'h0000_0001, 32'h0000_001F, "R10");
    // R11 illegal op and opx, R3 call and formats
    drive(enc_i(5'd1, 5'd2, 16'h1234, 6'h17), 32'h1111_1111, 32'h2222_2222, "R11");
    drive(enc_r(5'd1, 5'd2, 5'd3, 6'h3F, 5'd0), 32'h1111_1111, 32'h2222_2222, "R11");
    drive({26'h3FF_FFFF, 6'h00}, 32'h5, 32'h6, "R3");
    idle(1);
    check_quiet("R2");
    // R12 destination zero
    drive(enc_r(5'd3, 5'd4, 5'd0, 6'h31, 5'd0), 32'h10, 32'h20, "R12");
    drive(enc_i(5'd3, 5'd0, 16'h0001, 6'h04), 32'h10, 32'h0, "R12");
    drive(enc_i(5'd3, 5'd0, 16'h00FF, 6'h34), 32'h1, 32'h0, "R12");
    idle(3);
    // R2: every queued result must have appeared
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: actual %0d results missing expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule